// File: doc/BRIEF.md
# Byte-Lane Memory Access Sequencer

This block sits between a processor core and a 16-bit memory bus that addresses single bytes over a 20-bit (1 MiB) space. The core asks for a byte or a word, read or write, at any byte address. The block turns that request into one or two bus cycles. It drives the byte enables, steers each byte onto the correct half of the bus, and puts read bytes back in order before it returns them.

On this bus, even-addressed bytes use the low lane (bits 7..0) and odd-addressed bytes use the high lane (bits 15..8). Words are stored least significant byte first. A word at an even address fits one bus cycle. A word at an odd address is split into two single-byte cycles: the low byte goes over the high lane at the requested address, then the high byte goes over the low lane at the next address. The block reassembles the two halves and reports completion with a one-clock done pulse. It accepts a new request only while idle.

Top module: `bytelane_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `busy`, `done` and `mem_req` are low.
- R2: A word access at an even address A gives exactly one bus cycle, with address A, enables `mem_be`=2'b11 and the whole word on `mem_wdata`. A read returns `mem_rdata` unchanged.
- R3: A byte access gives one bus cycle at its own address. At an even address the enables are 2'b01 and the data uses bits 7..0. At an odd address the enables are 2'b10 and the data uses bits 15..8. A byte read returns the lane byte in bits 7..0 with bits 15..8 zero. Enables are never 2'b00 while `mem_req` is high.
- R4: A word access at an odd address A gives two bus cycles, in this order. The first is at A with enables 2'b10 and carries the low byte on bits 15..8. The second is at A+1 with enables 2'b01 and carries the high byte on bits 7..0. The returned word is {byte at A+1, byte at A}.
- R5: The second address of a split word wraps modulo 2^20, so a word at 0xFFFFF uses 0xFFFFF and then 0x00000.
- R6: `mem_wdata` is zero on every lane whose enable is low, and zero on both lanes during a read.
- R7: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_addr`, `mem_be` and `mem_wdata` hold their values into the next cycle.
- R8: `done` is high for exactly one clock, in the cycle after the edge that samples `mem_ready` high on the final bus cycle. In that cycle `rdata` holds the read result. `mem_req` is low while `done` is high.
- R9: A request (`req_valid` high) is accepted only when `busy` is low. `busy` rises in the next cycle and stays high up to and including the `done` cycle. Requests presented while busy are ignored and produce no bus cycle. With no access outstanding, `mem_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core presents an access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = single byte |
| req_addr | input | 20 | Byte address of the access |
| req_wdata | input | 16 | Write data (byte writes use bits 7..0) |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read result, valid with done |
| mem_req | output | 1 | Bus cycle request |
| mem_we | output | 1 | Bus cycle is a write |
| mem_addr | output | 20 | Bus byte address |
| mem_be | output | 2 | Lane enables {high, low}, active high |
| mem_wdata | output | 16 | Bus write lanes |
| mem_rdata | input | 16 | Bus read lanes |
| mem_ready | input | 1 | Memory completes the current bus cycle |

## Verification
The bench runs reads and writes of bytes at even and odd addresses and words at even and odd addresses, each with zero and with several wait states. These patterns separate a lane-steering error, a wrong enable code, a missing or extra split cycle, and a swapped reassembly. A word at the top of the address space shows whether the second address wraps or carries out. Reading back words after mixed-size writes checks that the little-endian byte order holds across both paths. A request held high while the block is busy checks that it is ignored and raises no extra bus cycle.

// File: rtl/bl_pkg.sv
package bl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_SECOND = 2'd2,
    ST_FINISH = 2'd3
  } bl_state_e;

  localparam logic [1:0] EN_NONE = 2'b00;
  localparam logic [1:0] EN_LO   = 2'b01;
  localparam logic [1:0] EN_HI   = 2'b10;
  localparam logic [1:0] EN_BOTH = 2'b11;

endpackage

// File: rtl/bl_lane_plan.sv
module bl_lane_plan
  import bl_pkg::*;
#(
  parameter int AW = 20,
  parameter int LW = 8,
  localparam int DW = 2 * LW
) (
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_word,
  input  logic          acc_write,
  input  logic [DW-1:0] acc_wdata,
  input  logic          second_half,
  output logic [AW-1:0] cyc_addr,
  output logic [1:0]    cyc_en,
  output logic [DW-1:0] cyc_wdata,
  output logic          needs_split
);

  logic [LW-1:0] lo_b, hi_b;
  logic [DW-1:0] lanes;

  assign lo_b = acc_wdata[LW-1:0];
  assign hi_b = acc_wdata[DW-1:LW];
  assign needs_split = acc_word & acc_addr[0];

  always_comb begin
    if (second_half) begin
      cyc_addr = acc_addr + AW'(1);
      cyc_en   = EN_LO;
      lanes    = {{LW{1'b0}}, hi_b};
    end else begin
      cyc_addr = acc_addr;
      if (acc_word && !acc_addr[0]) begin
        cyc_en = EN_BOTH;
        lanes  = acc_wdata;
      end else if (acc_addr[0]) begin
        cyc_en = EN_HI;
        lanes  = {lo_b, {LW{1'b0}}};
      end else begin
        cyc_en = EN_LO;
        lanes  = {{LW{1'b0}}, lo_b};
      end
    end
    cyc_wdata = acc_write ? lanes : '0;
  end

endmodule

// File: rtl/bl_read_merge.sv
module bl_read_merge
  import bl_pkg::*;
#(
  parameter int LW = 8,
  localparam int DW = 2 * LW
) (
  input  logic [1:0]    cyc_en,
  input  logic          second_half,
  input  logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] partial,
  output logic [DW-1:0] merged
);

  always_comb begin
    if (second_half) begin
      merged = {bus_rdata[LW-1:0], partial[LW-1:0]};
    end else begin
      unique case (cyc_en)
        EN_BOTH: merged = bus_rdata;
        EN_HI:   merged = {{LW{1'b0}}, bus_rdata[DW-1:LW]};
        default: merged = {{LW{1'b0}}, bus_rdata[LW-1:0]};
      endcase
    end
  end

endmodule

// File: rtl/bytelane_seq.sv
module bytelane_seq
  import bl_pkg::*;
#(
  parameter int AW = 20,
  parameter int LW = 8,
  localparam int DW = 2 * LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_word,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_be,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready
);

  bl_state_e     state;
  logic [AW-1:0] h_addr;
  logic          h_word, h_write;
  logic [DW-1:0] h_wdata;

  logic          in_idle;
  logic [AW-1:0] p_addr_in, p_addr_out;
  logic          p_word, p_write, p_second, p_split;
  logic [DW-1:0] p_wdata_in, p_wdata_out;
  logic [1:0]    p_en;
  logic [DW-1:0] merged;

  assign in_idle    = (state == ST_IDLE);
  assign p_addr_in  = in_idle ? req_addr  : h_addr;
  assign p_word     = in_idle ? req_word  : h_word;
  assign p_write    = in_idle ? req_write : h_write;
  assign p_wdata_in = in_idle ? req_wdata : h_wdata;
  assign p_second   = (state == ST_FIRST);

  bl_lane_plan #(.AW(AW), .LW(LW)) u_plan (
    .acc_addr    (p_addr_in),
    .acc_word    (p_word),
    .acc_write   (p_write),
    .acc_wdata   (p_wdata_in),
    .second_half (p_second),
    .cyc_addr    (p_addr_out),
    .cyc_en      (p_en),
    .cyc_wdata   (p_wdata_out),
    .needs_split (p_split)
  );

  bl_read_merge #(.LW(LW)) u_merge (
    .cyc_en      (mem_be),
    .second_half (state == ST_SECOND),
    .bus_rdata   (mem_rdata),
    .partial     (rdata),
    .merged      (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      h_addr    <= '0;
      h_word    <= 1'b0;
      h_write   <= 1'b0;
      h_wdata   <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      rdata     <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= EN_NONE;
      mem_wdata <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          done <= 1'b0;
          if (req_valid) begin
            h_addr    <= req_addr;
            h_word    <= req_word;
            h_write   <= req_write;
            h_wdata   <= req_wdata;
            mem_addr  <= p_addr_out;
            mem_be    <= p_en;
            mem_wdata <= p_wdata_out;
            mem_we    <= req_write;
            mem_req   <= 1'b1;
            busy      <= 1'b1;
            state     <= ST_FIRST;
          end
        end
        ST_FIRST: begin
          if (mem_ready) begin
            if (!h_write) rdata <= merged;
            if (p_split) begin
              mem_addr  <= p_addr_out;
              mem_be    <= p_en;
              mem_wdata <= p_wdata_out;
              state     <= ST_SECOND;
            end else begin
              mem_req   <= 1'b0;
              mem_we    <= 1'b0;
              mem_be    <= EN_NONE;
              mem_wdata <= '0;
              done      <= 1'b1;
              state     <= ST_FINISH;
            end
          end
        end
        ST_SECOND: begin
          if (mem_ready) begin
            if (!h_write) rdata <= merged;
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_be    <= EN_NONE;
            mem_wdata <= '0;
            done      <= 1'b1;
            state     <= ST_FINISH;
          end
        end
        default: begin
          done  <= 1'b0;
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/bytelane_seq_chk.sv
module bytelane_seq_chk #(
  parameter int AW = 20,
  parameter int LW = 8,
  localparam int DW = 2 * LW
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    mem_be,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ready
);

  // R7: a stalled bus cycle keeps its request, address, enables and data
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_be) && $stable(mem_wdata)));

  // R8: done lasts a single clock
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: done follows a completed bus cycle and the bus is quiet meanwhile
  a_r8_after_ready: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(mem_req && mem_ready) && !mem_req));

  // R9: an idle block accepts a request and becomes busy
  a_r9_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy);

  // R9: busy stays up until done has been shown
  a_r9_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);

  // R9: no bus cycle without an outstanding access
  a_r9_req_in_busy: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  // R3: an active cycle always enables at least one lane
  a_r3_some_lane: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_be != 2'b00));

  // R6: disabled lanes carry zeros
  a_r6_lo_quiet: assert property (@(posedge clk) disable iff (rst)
    (mem_req && (!mem_we || !mem_be[0])) |-> (mem_wdata[LW-1:0] == '0));

  a_r6_hi_quiet: assert property (@(posedge clk) disable iff (rst)
    (mem_req && (!mem_we || !mem_be[1])) |-> (mem_wdata[DW-1:LW] == '0));

endmodule

bind bytelane_seq bytelane_seq_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready)
);

// File: tb/test_bytelane_seq.sv
module test_bytelane_seq;
  localparam int AW = 20;
  localparam int LW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          busy, done, mem_req, mem_we;
  logic [DW-1:0] rdata, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_be;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_ready = 1'b0;

  bytelane_seq #(.AW(AW), .LW(LW)) i_bytelane_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  // Stimulus knobs written only by the main initial block
  int    cfg_waits = 0;
  string cfg_tag = "R2";

  // Model state written only by the negedge process
  int            checks = 0, fails = 0, cyc = 0, wcnt = 0;
  logic [7:0]    bm [256];
  logic [AW-1:0] q_addr [$];
  logic [1:0]    q_be [$];
  logic          q_we [$];
  logic [DW-1:0] q_wd [$];
  string         q_tag [$];
  logic          exp_busy = 1'b0, final_hs = 1'b0, exp_read = 1'b0, r1_seen = 1'b0;
  logic [DW-1:0] exp_rdata = '0;
  string         exp_tag = "";
  logic          p_rst = 1'b1, p_req_valid = 1'b0, p_req_write = 1'b0, p_req_word = 1'b0;
  logic [AW-1:0] p_req_addr = '0, p_addr = '0;
  logic [DW-1:0] p_req_wdata = '0, p_wdata = '0;
  logic          p_mem_req = 1'b0, p_we = 1'b0, p_ready = 1'b0, p_done = 1'b0;
  logic [1:0]    p_be = '0;

  function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  function automatic void push(logic [AW-1:0] a, logic [1:0] be, logic we,
                               logic [DW-1:0] wd, string tag);
    q_addr.push_back(a); q_be.push_back(be); q_we.push_back(we);
    q_wd.push_back(wd); q_tag.push_back(tag);
  endfunction

  always @(negedge clk) begin
    logic          fin;
    logic [AW-1:0] a, a1;
    logic [AW-1:0] ea;
    logic [1:0]    eb;
    logic          ew;
    logic [DW-1:0] ed;
    string         et;
    cyc++;
    // replay the previous rising edge
    if (p_rst) begin
      exp_busy = 1'b0; final_hs = 1'b0;
      q_addr.delete(); q_be.delete(); q_we.delete(); q_wd.delete(); q_tag.delete();
      for (int i = 0; i < 256; i++) bm[i] = 8'(i * 37 + 11);
    end else begin
      fin = 1'b0;
      if (p_mem_req && p_ready) begin
        if (q_addr.size() == 0) begin
          chk("R9 unexpected bus cycle", 32'(p_addr), 32'hFFFFFFFF);
        end else begin
          ea = q_addr.pop_front(); eb = q_be.pop_front(); ew = q_we.pop_front();
          ed = q_wd.pop_front(); et = q_tag.pop_front();
          chk({et, " bus address"}, 32'(p_addr), 32'(ea));
          chk({et, " lane enables"}, 32'(p_be), 32'(eb));
          chk({et, " write flag"}, 32'(p_we), 32'(ew));
          chk({et, " R6 lane data"}, 32'(p_wdata), 32'(ed));
          if (q_addr.size() == 0) fin = 1'b1;
        end
        if (p_we && p_be[0]) bm[{p_addr[7:1], 1'b0}] = p_wdata[7:0];
        if (p_we && p_be[1]) bm[{p_addr[7:1], 1'b1}] = p_wdata[15:8];
        wcnt = cfg_waits;
      end
      if (!exp_busy && p_req_valid) begin
        a  = p_req_addr;
        a1 = a + 20'd1;
        exp_busy = 1'b1;
        exp_read = !p_req_write;
        exp_tag  = cfg_tag;
        wcnt     = cfg_waits;
        if (!p_req_word) begin
          exp_rdata = {8'h00, bm[a[7:0]]};
          if (a[0]) push(a, 2'b10, p_req_write, p_req_write ? {p_req_wdata[7:0], 8'h00} : 16'h0, "R3 odd byte");
          else      push(a, 2'b01, p_req_write, p_req_write ? {8'h00, p_req_wdata[7:0]} : 16'h0, "R3 even byte");
        end else begin
          exp_rdata = {bm[a1[7:0]], bm[a[7:0]]};
          if (!a[0]) begin
            push(a, 2'b11, p_req_write, p_req_write ? p_req_wdata : 16'h0, "R2 aligned word");
          end else begin
            push(a, 2'b10, p_req_write, p_req_write ? {p_req_wdata[7:0], 8'h00} : 16'h0, "R4 split first");
            push(a1, 2'b01, p_req_write, p_req_write ? {8'h00, p_req_wdata[15:8]} : 16'h0,
                 (a == 20'hFFFFF) ? "R5 wrapped second" : "R4 split second");
          end
        end
      end else if (p_done) begin
        exp_busy = 1'b0;
      end
      final_hs = fin;
    end
    // compare this cycle's outputs with the model
    if (!rst) begin
      if (!r1_seen) begin
        r1_seen = 1'b1;
        chk("R1 busy after reset", 32'(busy), 32'd0);
        chk("R1 done after reset", 32'(done), 32'd0);
        chk("R1 mem_req after reset", 32'(mem_req), 32'd0);
      end
      chk("R9 busy", 32'(busy), 32'(exp_busy));
      chk("R8 done", 32'(done), 32'(final_hs));
      if (!exp_busy) chk("R9 bus idle", 32'(mem_req), 32'd0);
      if (final_hs && exp_read) chk({exp_tag, " R8 read data"}, 32'(rdata), 32'(exp_rdata));
      if (p_mem_req && !p_ready && !p_rst) begin
        chk("R7 request held", 32'(mem_req), 32'd1);
        chk("R7 address held", 32'(mem_addr), 32'(p_addr));
        chk("R7 enables held", 32'(mem_be), 32'(p_be));
      end
    end
    // record this cycle for the next edge
    p_rst = rst; p_req_valid = req_valid; p_req_write = req_write; p_req_word = req_word;
    p_req_addr = req_addr; p_req_wdata = req_wdata;
    p_mem_req = mem_req; p_we = mem_we; p_addr = mem_addr; p_be = mem_be;
    p_wdata = mem_wdata; p_done = done;
    // memory responder
    if (mem_req && !rst) begin
      mem_ready = (wcnt == 0);
      if (wcnt > 0) wcnt--;
      mem_rdata = {bm[{mem_addr[7:1], 1'b1}], bm[{mem_addr[7:1], 1'b0}]};
    end else begin
      mem_ready = 1'b0;
    end
    p_ready = mem_ready;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=idle", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic access(input logic wr, input logic wd_word, input logic [AW-1:0] addr,
                        input logic [DW-1:0] data, input int waits, input string tag,
                        input int linger);
    @(posedge clk); #2;
    cfg_waits = waits; cfg_tag = tag;
    req_write = wr; req_word = wd_word; req_addr = addr; req_wdata = data;
    req_valid = 1'b1;
    @(posedge clk); #2;
    // a lingering request while busy must be ignored (R9)
    for (int k = 0; k < linger; k++) begin
      req_addr = addr ^ 20'h00040; req_write = !wr;
      @(posedge clk); #2;
    end
    req_valid = 1'b0;
    @(negedge clk);
    while (exp_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    // reads of each shape, without and with wait states
    access(1'b0, 1'b1, 20'h01234, 16'h0, 0, "R2", 0);
    access(1'b0, 1'b1, 20'h01236, 16'h0, 3, "R2", 0);
    access(1'b0, 1'b0, 20'h00010, 16'h0, 0, "R3", 0);
    access(1'b0, 1'b0, 20'h00011, 16'h0, 2, "R3", 0);
    access(1'b0, 1'b1, 20'h01235, 16'h0, 0, "R4", 0);
    access(1'b0, 1'b1, 20'h0ABC7, 16'h0, 2, "R4", 0);
    // writes of each shape
    access(1'b1, 1'b1, 20'h00020, 16'hBEEF, 0, "R2", 0);
    access(1'b1, 1'b1, 20'h00031, 16'hC0DE, 1, "R4", 0);
    access(1'b1, 1'b0, 20'h00041, 16'h00A5, 0, "R3", 0);
    access(1'b1, 1'b0, 20'h00042, 16'h005A, 2, "R3", 0);
    // read back across sizes: little-endian order
    access(1'b0, 1'b1, 20'h00030, 16'h0, 0, "R4", 0);
    access(1'b0, 1'b1, 20'h00031, 16'h0, 1, "R4", 0);
    access(1'b0, 1'b1, 20'h00041, 16'h0, 0, "R4", 0);
    access(1'b0, 1'b0, 20'h00021, 16'h0, 0, "R3", 0);
    // top of the address space
    access(1'b0, 1'b1, 20'hFFFFF, 16'h0, 0, "R5", 0);
    access(1'b1, 1'b1, 20'hFFFFF, 16'h1357, 2, "R5", 0);
    access(1'b0, 1'b1, 20'hFFFFF, 16'h0, 1, "R5", 0);
    // requests held while busy
    access(1'b0, 1'b1, 20'h00051, 16'h0, 3, "R9", 3);
    access(1'b1, 1'b0, 20'h00060, 16'h0077, 4, "R9", 2);
    access(1'b0, 1'b0, 20'h00060, 16'h0, 0, "R9", 0);
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule